// File: doc/BRIEF.md
# Multi-Operand Function Unit Sequencer

This block is the control and latching front end of one function unit in a scoreboarded core. An instruction that reads up to three source operands and writes up to two results is handed to it by an issue strobe, along with masks saying which operands it reads and which results it writes. From then on the unit asks for register-file read ports one operand at a time. Each operand has its own request line and its own grant line, so a single free port is enough for the unit to move forward. Each operand value is captured when its grant arrives.

When every needed operand is held, the unit passes them to a shared execution pipeline for one cycle, together with a fixed tag that identifies the unit. It then watches the pipeline's result bus for that tag. After it takes its results, it asks for write ports, again one result at a time, and it goes idle when the last needed write has been granted. A unit with no result goes idle as soon as it has dispatched. A kill input stops the operation at once. Because a killed operation may still have a result in the pipeline, the next result carrying this unit's tag is thrown away.

Top module: `multi_op_cu`

## Requirements
- R1: After reset, busy, every read request, every write request, the read-release flag and the dispatch strobe are all low.
- R2: An issue while idle sets busy and, from the next cycle, drives the read requests equal to the issued read mask (bit i is operand i). An issue while busy has no effect on the requests.
- R3: A go-read on a pending operand i clears read request i in the next cycle and captures operand data slice i (bits i*DATA_W upward) into output latch slice i at that edge. A go-read on an operand that is not pending changes neither the requests nor that latch.
- R4: Go-reads may arrive in any order or combination, including all three in one cycle.
- R5: In the cycle after the last needed read grant, or in the cycle after issue when no read is needed, the dispatch strobe is high for exactly one cycle and the tag output equals UNIT_TAG.
- R6: Read-release is high from the cycle after an issue with at least one needed read until the edge of the final read grant. A read request is never high while read-release is low.
- R7: An operation with an empty write mask drops busy at the edge that ends its dispatch cycle, without waiting for a result.
- R8: Write requests stay low until a result arrives with the valid flag high and a tag equal to UNIT_TAG. From the next cycle the write requests equal the issued write mask and the result outputs hold the result data. A result with any other tag is ignored.
- R9: A go-write on a pending result clears that write request in the next cycle. Go-writes on results that are not pending have no effect. Busy drops at the edge of the last needed write grant.
- R10: A kill clears busy, all requests and read-release at the next edge, and a kill wins over an issue in the same cycle.
- R11: If a kill hits while the unit waits for its result, the next result tagged UNIT_TAG is discarded even when a new operation is waiting, and the one after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueIn | input | 1 | Start a new operation |
| rdNeedIn | input | 3 | Operands the issued operation reads |
| wrNeedIn | input | 2 | Results the issued operation writes |
| goRd | input | 3 | Per-operand read-port grants |
| goWr | input | 2 | Per-result write-port grants |
| opData | input | 3*DATA_W | Register-file read data, one slice per operand |
| pipeResValid | input | 1 | Pipeline result valid |
| pipeResTag | input | TAG_W | Tag of the returning result |
| pipeResData | input | 2*DATA_W | Returning result data |
| killIn | input | 1 | Cancel the current operation |
| busy | output | 1 | Unit holds an operation |
| rdReq | output | 3 | Per-operand read requests |
| wrReq | output | 2 | Per-result write requests |
| rdRelease | output | 1 | Read requests allowed |
| pipeValid | output | 1 | Operands presented to the pipeline |
| pipeTag | output | TAG_W | Unit tag sent with the operands |
| opLatch | output | 3*DATA_W | Latched operand values |
| resOut | output | 2*DATA_W | Latched result values |

## Verification
A wrong pending mask appears on the read or write request lines in the very next cycle, and the bench compares those lines against its own pending model after every grant. A missed or wrong capture shows on the operand latch outputs at the grant edge, so the bench checks the whole latch bus after each grant, including the slices it expects to stay unchanged. A bad state transition shows within one cycle, either as a missing or doubled dispatch pulse or as busy dropping at the wrong edge. A wrong stale-result flag only shows when the next tagged result arrives, so the kill cases place that result right after a fresh operation reaches its waiting state.

// File: rtl/mop_cu_pkg.sv
package mop_cu_pkg;
  parameter int NRD = 3;
  parameter int NWR = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WRITE = 2'd3
  } cuState_e;

  typedef struct packed {
    logic [NRD-1:0] capOp;
    logic           capRes;
  } dpStrobe_t;
endpackage

// File: rtl/mop_cu_dpath.sv
module mop_cu_dpath
  import mop_cu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [NRD*DATA_W-1:0] opData,
  input  logic [NWR*DATA_W-1:0] resData,
  output logic [NRD*DATA_W-1:0] opLatch,
  output logic [NWR*DATA_W-1:0] resOut
);
  for (genvar i = 0; i < NRD; i++) begin : g_op
    always_ff @(posedge clk) begin
      if (!rstN)
        opLatch[i*DATA_W +: DATA_W] <= '0;
      else if (strobe.capOp[i])
        opLatch[i*DATA_W +: DATA_W] <= opData[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resOut <= '0;
    else if (strobe.capRes) resOut <= resData;
  end
endmodule

// File: rtl/mop_cu_ctrl.sv
module mop_cu_ctrl
  import mop_cu_pkg::*;
#(
  parameter int TAG_W    = 3,
  parameter int UNIT_TAG = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueIn,
  input  logic [NRD-1:0]   rdNeedIn,
  input  logic [NWR-1:0]   wrNeedIn,
  input  logic [NRD-1:0]   goRd,
  input  logic [NWR-1:0]   goWr,
  input  logic             pipeResValid,
  input  logic [TAG_W-1:0] pipeResTag,
  input  logic             killIn,
  output logic             busy,
  output logic [NRD-1:0]   rdReq,
  output logic [NWR-1:0]   wrReq,
  output logic             rdRelease,
  output logic             pipeValid,
  output dpStrobe_t        strobe
);
  localparam logic [TAG_W-1:0] MyTag = TAG_W'(UNIT_TAG);

  cuState_e       state;
  logic [NRD-1:0] rdPend;
  logic [NWR-1:0] wrPend;
  logic [NWR-1:0] wrNeedQ;
  logic           rdRel;
  logic           stale;

  logic           ownRes;
  logic           accept;
  logic           readsDone;
  logic [NRD-1:0] rdLeft;
  logic [NWR-1:0] wrLeft;

  assign ownRes    = pipeResValid && (pipeResTag == MyTag);
  assign accept    = ownRes && !stale && (state == ST_EXEC);
  assign readsDone = (state == ST_READ) && (rdPend == '0);
  assign rdLeft    = rdPend & ~goRd;
  assign wrLeft    = wrPend & ~goWr;

  assign busy      = (state != ST_IDLE);
  assign rdReq     = rdPend & {NRD{rdRel}};
  assign wrReq     = wrPend;
  assign rdRelease = rdRel;
  assign pipeValid = readsDone && !killIn;

  assign strobe.capOp  = (state == ST_READ) ? (goRd & rdPend) : '0;
  assign strobe.capRes = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdPend  <= '0;
      wrPend  <= '0;
      wrNeedQ <= '0;
      rdRel   <= 1'b0;
      stale   <= 1'b0;
    end else begin
      stale <= (stale && !ownRes) || (killIn && (state == ST_EXEC) && !accept);
      if (killIn) begin
        state  <= ST_IDLE;
        rdPend <= '0;
        wrPend <= '0;
        rdRel  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (issueIn) begin
            state   <= ST_READ;
            rdPend  <= rdNeedIn;
            wrNeedQ <= wrNeedIn;
            rdRel   <= (rdNeedIn != '0);
          end
          ST_READ: begin
            rdPend <= rdLeft;
            if (rdLeft == '0) rdRel <= 1'b0;
            if (rdPend == '0)
              state <= (wrNeedQ == '0) ? ST_IDLE : ST_EXEC;
          end
          ST_EXEC: if (accept) begin
            state  <= ST_WRITE;
            wrPend <= wrNeedQ;
          end
          ST_WRITE: begin
            wrPend <= wrLeft;
            if (wrLeft == '0) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq != '0) || (wrReq != '0)) |-> busy);

  p_issue_sets_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueIn && !busy && !killIn) |=> busy);

  p_req_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq != '0) |-> rdRelease);

  p_writes_after_reads_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq != '0) |-> (!rdRelease && rdReq == '0));

  p_dispatch_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    pipeValid |=> !pipeValid);

  p_kill_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    killIn |=> (!busy && rdReq == '0 && wrReq == '0 && !rdRelease));

  for (genvar i = 0; i < NRD; i++) begin : g_rdchk
    p_grant_drops_req_r3: assert property (@(posedge clk) disable iff (!rstN)
      (rdReq[i] && goRd[i]) |=> !rdReq[i]);
  end

  for (genvar j = 0; j < NWR; j++) begin : g_wrchk
    p_grant_drops_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
      (wrReq[j] && goWr[j]) |=> !wrReq[j]);
  end
endmodule

// File: rtl/multi_op_cu.sv
module multi_op_cu
  import mop_cu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int UNIT_TAG = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueIn,
  input  logic [NRD-1:0]        rdNeedIn,
  input  logic [NWR-1:0]        wrNeedIn,
  input  logic [NRD-1:0]        goRd,
  input  logic [NWR-1:0]        goWr,
  input  logic [NRD*DATA_W-1:0] opData,
  input  logic                  pipeResValid,
  input  logic [TAG_W-1:0]      pipeResTag,
  input  logic [NWR*DATA_W-1:0] pipeResData,
  input  logic                  killIn,
  output logic                  busy,
  output logic [NRD-1:0]        rdReq,
  output logic [NWR-1:0]        wrReq,
  output logic                  rdRelease,
  output logic                  pipeValid,
  output logic [TAG_W-1:0]      pipeTag,
  output logic [NRD*DATA_W-1:0] opLatch,
  output logic [NWR*DATA_W-1:0] resOut
);
  dpStrobe_t strobe;

  assign pipeTag = TAG_W'(UNIT_TAG);

  mop_cu_ctrl #(.TAG_W(TAG_W), .UNIT_TAG(UNIT_TAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueIn(issueIn), .rdNeedIn(rdNeedIn),
    .wrNeedIn(wrNeedIn), .goRd(goRd), .goWr(goWr),
    .pipeResValid(pipeResValid), .pipeResTag(pipeResTag), .killIn(killIn),
    .busy(busy), .rdReq(rdReq), .wrReq(wrReq), .rdRelease(rdRelease),
    .pipeValid(pipeValid), .strobe(strobe)
  );

  mop_cu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opData(opData),
    .resData(pipeResData), .opLatch(opLatch), .resOut(resOut)
  );
endmodule

// File: tb/multi_op_cu_bench.sv
`timescale 1ns/1ps
module multi_op_cu_bench;
  localparam int DATA_W   = 16;
  localparam int TAG_W    = 3;
  localparam int UNIT_TAG = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueIn = 1'b0;
  logic [2:0] rdNeedIn = '0;
  logic [1:0] wrNeedIn = '0;
  logic [2:0] goRd = '0;
  logic [1:0] goWr = '0;
  logic [3*DATA_W-1:0] opData = '0;
  logic pipeResValid = 1'b0;
  logic [TAG_W-1:0] pipeResTag = '0;
  logic [2*DATA_W-1:0] pipeResData = '0;
  logic killIn = 1'b0;
  logic busy, rdRelease, pipeValid;
  logic [2:0] rdReq;
  logic [1:0] wrReq;
  logic [TAG_W-1:0] pipeTag;
  logic [3*DATA_W-1:0] opLatch;
  logic [2*DATA_W-1:0] resOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  multi_op_cu #(.DATA_W(DATA_W), .TAG_W(TAG_W), .UNIT_TAG(UNIT_TAG)) u_multi_op_cu (
    .clk(clk), .rstN(rstN), .issueIn(issueIn), .rdNeedIn(rdNeedIn),
    .wrNeedIn(wrNeedIn), .goRd(goRd), .goWr(goWr), .opData(opData),
    .pipeResValid(pipeResValid), .pipeResTag(pipeResTag),
    .pipeResData(pipeResData), .killIn(killIn), .busy(busy), .rdReq(rdReq),
    .wrReq(wrReq), .rdRelease(rdRelease), .pipeValid(pipeValid),
    .pipeTag(pipeTag), .opLatch(opLatch), .resOut(resOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [3*DATA_W-1:0] mergeOps(input logic [3*DATA_W-1:0] old,
      input logic [3*DATA_W-1:0] din, input logic [2:0] take);
    logic [3*DATA_W-1:0] r = old;
    for (int i = 0; i < 3; i++)
      if (take[i]) r[i*DATA_W +: DATA_W] = din[i*DATA_W +: DATA_W];
    return r;
  endfunction

  task automatic runOp(input logic [2:0] rdN, input logic [1:0] wrN,
                       input bit allAtOnce, input bit tryReissue);
    logic [2:0] pend;
    logic [1:0] wpend;
    logic [2:0] g;
    logic [1:0] gw;
    logic [3*DATA_W-1:0] expOp;
    logic [2*DATA_W-1:0] res;
    bit first = 1;
    expOp = opLatch;
    issueIn = 1; rdNeedIn = rdN; wrNeedIn = wrN;
    tick();
    issueIn = 0;
    chk("R2 busy after issue", 64'(busy), 64'(1));
    chk("R2 read requests", 64'(rdReq), 64'(rdN));
    chk("R6 release after issue", 64'(rdRelease), 64'(rdN != 0));
    pend = rdN;
    while (pend != 0) begin
      g = allAtOnce ? 3'b111 : 3'($urandom);
      for (int i = 0; i < 3; i++) opData[i*DATA_W +: DATA_W] = DATA_W'($urandom);
      expOp = mergeOps(expOp, opData, g & pend);
      goRd = g;
      if (tryReissue && first) begin issueIn = 1; rdNeedIn = ~rdN; end
      tick();
      goRd = 0; issueIn = 0; first = 0;
      pend = pend & ~g;
      chk("R3 R4 pending reads", 64'(rdReq), 64'(pend));
      chk("R3 operand latch", 64'(opLatch), 64'(expOp));
      chk("R6 release", 64'(rdRelease), 64'(pend != 0));
      chk("R8 no write during reads", 64'(wrReq), 64'(0));
    end
    chk("R5 dispatch strobe", 64'(pipeValid), 64'(1));
    chk("R5 tag", 64'(pipeTag), 64'(UNIT_TAG));
    tick();
    chk("R5 single pulse", 64'(pipeValid), 64'(0));
    if (wrN == 0) begin
      chk("R7 done without result", 64'(busy), 64'(0));
      return;
    end
    chk("R8 busy waiting", 64'(busy), 64'(1));
    chk("R8 no write before result", 64'(wrReq), 64'(0));
    res = {DATA_W'($urandom), DATA_W'($urandom)};
    pipeResData = res; pipeResValid = 1; pipeResTag = TAG_W'(UNIT_TAG) ^ TAG_W'(1);
    tick();
    chk("R8 foreign tag ignored", 64'(wrReq), 64'(0));
    pipeResTag = TAG_W'(UNIT_TAG);
    tick();
    pipeResValid = 0;
    chk("R8 write requests", 64'(wrReq), 64'(wrN));
    chk("R8 result latch", 64'(resOut), 64'(res));
    wpend = wrN;
    while (wpend != 0) begin
      gw = 2'($urandom);
      goWr = gw;
      tick();
      goWr = 0;
      wpend = wpend & ~gw;
      chk("R9 pending writes", 64'(wrReq), 64'(wpend));
      chk("R9 busy", 64'(busy), 64'(wpend != 0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rstN = 1;
    tick();
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 rdReq", 64'(rdReq), 64'(0));
    chk("R1 wrReq", 64'(wrReq), 64'(0));
    chk("R1 release", 64'(rdRelease), 64'(0));
    chk("R1 dispatch", 64'(pipeValid), 64'(0));

    runOp(3'b111, 2'b11, 1, 0);   // R4 all grants in one cycle
    runOp(3'b000, 2'b00, 0, 0);   // R5 R7 no reads, no writes
    runOp(3'b000, 2'b01, 0, 0);
    runOp(3'b101, 2'b10, 0, 1);   // R2 issue while busy
    for (int k = 0; k < 40; k++)
      runOp(3'($urandom), 2'($urandom), 0, ($urandom % 4) == 0);

    // R10: kill during reads, with a simultaneous issue
    issueIn = 1; rdNeedIn = 3'b011; wrNeedIn = 2'b01;
    tick();
    issueIn = 1; rdNeedIn = 3'b111; killIn = 1;
    tick();
    issueIn = 0; killIn = 0;
    chk("R10 busy cleared", 64'(busy), 64'(0));
    chk("R10 reads cleared", 64'(rdReq), 64'(0));
    chk("R10 release cleared", 64'(rdRelease), 64'(0));
    tick();
    chk("R10 kill beats issue", 64'(busy), 64'(0));

    // R11: kill while waiting for the result
    issueIn = 1; rdNeedIn = 3'b000; wrNeedIn = 2'b01;
    tick(); issueIn = 0;
    tick();
    chk("R11 waiting", 64'(busy), 64'(1));
    killIn = 1;
    tick(); killIn = 0;
    chk("R10 kill in wait", 64'(busy), 64'(0));
    issueIn = 1; rdNeedIn = 3'b000; wrNeedIn = 2'b10;
    tick(); issueIn = 0;
    tick();
    pipeResValid = 1; pipeResTag = TAG_W'(UNIT_TAG); pipeResData = 32'h1111_2222;
    tick();
    chk("R11 stale result dropped", 64'(wrReq), 64'(0));
    chk("R11 still busy", 64'(busy), 64'(1));
    pipeResData = 32'h3333_4444;
    tick(); pipeResValid = 0;
    chk("R11 next result taken", 64'(wrReq), 64'(2'b10));
    chk("R11 result data", 64'(resOut), 64'(32'h3333_4444));
    goWr = 2'b01;
    tick();
    chk("R9 unneeded grant ignored", 64'(wrReq), 64'(2'b10));
    goWr = 2'b10;
    tick(); goWr = 0;
    chk("R9 idle after writes", 64'(busy), 64'(0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule